// File: doc/BRIEF.md
# Fault-Injecting Miter Test Harness

This block is a self-checking comparison harness for emulating transient faults in logic. A maximal-length linear feedback shift register generates a fresh pseudo-random vector every cycle. The same vector feeds two instances of a small synchronous example circuit. One instance is the golden reference. The other has an XOR gate on each of its selectable internal gate outputs. Each XOR is driven by one bit of the `inject` bus, so a line is inverted for exactly as long as its inject bit is high.

A registered comparator checks the primary outputs of the two instances and raises `mismatch` when any bit differs. No stimulus or expected response is stored. Everything is generated live, which allows test runs of any length. Pulsing `run_restart` returns the generator and both circuit copies to their starting state together, so every run replays the same stimulus. Surrounding logic decides when to inject and collects statistics. That logic treats `mismatch` as lagging the compared cycle by one clock.

The example circuit has eight internal nodes, numbered 0 to 7:
- Node 5 is the parity of the input vector. It feeds only a parity register, which is an output bit, so a fault on it is sequential.
- Node 6 is input bit 5 XOR input bit 6. It drives output bit 2 directly, so a fault on it is purely combinational.

Top module: `miter_harness`

## Requirements
- R1: One cycle after `rst_n` is low or `run_restart` is high, `vector` equals the nonzero parameter SEED (default 8'h5A) and `mismatch` is 0.
- R2: In every other cycle, the generator steps by a right shift. If the bit shifted out was 1, the result is XORed with the TAPS mask (default 8'hB8).
- R3: `vector` is never all-zero, and it returns to SEED after exactly 2^W-1 steps.
- R4: Both copies receive the same vector. From a reset or restart, as long as `inject` stays all-zero, `mismatch` stays 0.
- R5: Bit k of `inject` inverts internal node k only while it is high. A single-cycle pulse on bit 6 (which drives output bit 2 directly) gives `mismatch` = 1 for exactly one cycle.
- R6: `mismatch` is registered: its value after a clock edge reflects the comparison made in the cycle before that edge.
- R7: A single-cycle pulse on bit 5 gives no mismatch for the injection cycle. `mismatch` is then 1 from two edges after the pulse starts and stays 1 until a restart.
- R8: `run_restart` clears any divergence between the copies and replays exactly the vector sequence of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_restart | input | 1 | Synchronous restart of generator, both copies and comparator |
| inject | input | F | Per-node fault enables for the faulty copy |
| vector | output | W | Current generator vector applied to both copies |
| mismatch | output | 1 | Registered output-difference flag |

## Verification
The bench builds the harness with W=8, F=8, SEED=8'h5A and TAPS=8'hB8.

With these values, a full generator period of 255 steps fits in one short run. This allows the period, the absence of the zero state and each single step to be checked against a model taken from the requirements.

Setting F equal to the node count makes both the combinational-only node and the parity node injectable. This allows the bench to show a one-cycle fault and a fault that persists until restart, and then confirm that a restart replays the recorded vectors.

// File: rtl/miter_pkg.sv
// Shared constants and the generator step function for the miter harness.
// Assumes generator widths of at most 32 bits.
package miter_pkg;
    localparam int NODE_CNT = 8;   // injectable nodes in the example circuit
    localparam int PO_W     = 4;   // primary outputs of the example circuit

    // One Galois right-shift step of the vector generator.
    function automatic logic [31:0] lfsr_step(input logic [31:0] cur, input logic [31:0] taps);
        logic [31:0] nxt;
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ taps;
        return nxt;
    endfunction
endpackage

// File: rtl/vec_lfsr.sv
// Pseudo-random vector source: Galois LFSR, loaded with SEED on reset or clear.
// Assumes TAPS describes a primitive polynomial and SEED is nonzero.
module vec_lfsr #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8,
    parameter logic [W-1:0]   SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] vec
);
    localparam logic [31:0] TAPS32 = 32'(TAPS);

    logic [31:0] step_full;

    // Next-state value from the shared step function.
    always_comb step_full = miter_pkg::lfsr_step(32'(vec), TAPS32);

    // State register: seed on reset or clear, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) vec <= SEED;
        else               vec <= step_full[W-1:0];
    end
endmodule

// File: rtl/probe_circuit.sv
// Small synchronous example circuit with an XOR on each internal node.
// Node 5 (input parity) feeds only a parity register; node 6 drives output 2.
// Assumes W >= 8; the flip bits are all zero for the golden copy.
module probe_circuit #(
    parameter int W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic [W-1:0]                    vin,
    input  logic [miter_pkg::NODE_CNT-1:0]  flip,
    output logic [miter_pkg::PO_W-1:0]      po
);
    logic [2:0] st_q;
    logic       par_q;
    logic g0, g1, g2, g3, g4, g5, g6, g7;

    // Node evaluation, each node XORed with its own flip control.
    always_comb begin
        g0 = (vin[0] & vin[1]) ^ flip[0];
        g1 = (vin[2] | st_q[0]) ^ flip[1];
        g2 = (g0 ^ st_q[1]) ^ flip[2];
        g3 = (g1 & vin[3]) ^ flip[3];
        g4 = (g2 | vin[4]) ^ flip[4];
        g5 = (^vin) ^ flip[5];
        g6 = (vin[5] ^ vin[6]) ^ flip[6];
        g7 = (g3 ^ g4 ^ vin[7]) ^ flip[7];
    end

    // Primary outputs: parity register, a direct node, and mixed logic.
    always_comb po = {par_q, g6, g7, g2 & st_q[2]};

    // State and parity registers, cleared on reset or run restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q  <= '0;
            par_q <= 1'b0;
        end else begin
            st_q  <= {g7, g4, g3};
            par_q <= par_q ^ g5;
        end
    end
endmodule

// File: rtl/miter_harness.sv
// Top: generator driving a golden and a fault-injected copy, with a registered
// output comparator. Assumes F <= NODE_CNT; nodes at index F and above are never flipped.
module miter_harness #(
    parameter int           W    = 8,
    parameter int           F    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_restart,
    input  logic [F-1:0] inject,
    output logic [W-1:0] vector,
    output logic         mismatch
);
    import miter_pkg::*;

    logic [NODE_CNT-1:0] flip_gold;
    logic [NODE_CNT-1:0] flip_fault;
    logic [PO_W-1:0]     po_gold;
    logic [PO_W-1:0]     po_fault;
    logic                mismatch_q;

    assign flip_gold = '0;

    // Map inject bits onto the injectable nodes; the rest are tied off.
    for (genvar k = 0; k < NODE_CNT; k++) begin : g_flip
        if (k < F) begin : g_on
            assign flip_fault[k] = inject[k];
        end else begin : g_off
            assign flip_fault[k] = 1'b0;
        end
    end

    vec_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) gen_i (
        .clk(clk), .rst_n(rst_n), .clr(run_restart), .vec(vector)
    );

    probe_circuit #(.W(W)) gold_i (
        .clk(clk), .rst_n(rst_n), .clr(run_restart),
        .vin(vector), .flip(flip_gold), .po(po_gold)
    );

    probe_circuit #(.W(W)) fault_i (
        .clk(clk), .rst_n(rst_n), .clr(run_restart),
        .vin(vector), .flip(flip_fault), .po(po_fault)
    );

    // Comparator register: one-cycle pipeline offset, cleared with the run.
    always_ff @(posedge clk) begin
        if (!rst_n || run_restart) mismatch_q <= 1'b0;
        else                       mismatch_q <= |(po_gold ^ po_fault);
    end

    assign mismatch = mismatch_q;
endmodule

// File: rtl/miter_harness_chk.sv
// Checker for the miter harness, bound to every instance of the top.
module miter_harness_chk #(
    parameter int           W    = 8,
    parameter int           F    = 8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_restart,
    input logic [F-1:0] inject,
    input logic [W-1:0] vector,
    input logic         mismatch
);
    logic dirty_q;

    // Remembers whether any fault was injected since the last reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || run_restart) dirty_q <= 1'b0;
        else                       dirty_q <= dirty_q | (|inject);
    end

    assert_restart_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_restart |=> (vector == SEED && !mismatch));

    assert_vector_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vector != '0);

    assert_vector_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_restart |=> vector != $past(vector));

    assert_clean_no_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_restart && !dirty_q && inject == '0) |=> !mismatch);
endmodule

bind miter_harness miter_harness_chk #(.W(W), .F(F), .SEED(SEED)) chk_i (
    .clk(clk), .rst_n(rst_n), .run_restart(run_restart),
    .inject(inject), .vector(vector), .mismatch(mismatch)
);

// File: tb/miter_harness_tb_top.sv
`timescale 1ns/1ps
module miter_harness_tb_top;
    localparam int           W    = 8;
    localparam int           F    = 8;
    localparam logic [W-1:0] TAPS = 8'hB8;
    localparam logic [W-1:0] SEED = 8'h5A;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_restart = 1'b0;
    logic [F-1:0] inject = '0;
    logic [W-1:0] vector;
    logic         mismatch;

    int checks = 0;
    int errors = 0;
    item_t sb_q[$];
    logic [W-1:0] model;
    logic [W-1:0] rec[16];
    bit finished = 0;

    always #2.5 clk = ~clk;

    miter_harness #(.W(W), .F(F), .TAPS(TAPS), .SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_restart(run_restart),
        .inject(inject), .vector(vector), .mismatch(mismatch)
    );

    function automatic logic [W-1:0] next_vec(input logic [W-1:0] v);
        return (v >> 1) ^ (v[0] ? TAPS : '0);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected comparator result.
    task automatic cyc(input logic [F-1:0] inj, input bit rs, input logic exp, input string tag);
        item_t it;
        inject = inj;
        run_restart = rs;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        model = rs ? SEED : next_vec(model);
        @(negedge clk);
        check(vector == model, rs ? "R1 restart seed" : "R2 step", int'(vector), int'(model));
    endtask

    // Monitor: compare the registered flag just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(mismatch == it.exp, it.tag, int'(mismatch), int'(it.exp));
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int period;
        int seen_zero;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model = SEED;
        check(vector == SEED, "R1 reset vector", int'(vector), int'(SEED));
        check(mismatch == 1'b0, "R1 reset mismatch", int'(mismatch), 0);

        // Clean run over more than one full period.
        period = 0;
        seen_zero = 0;
        for (int i = 0; i < 300; i++) begin
            cyc('0, 1'b0, 1'b0, "R4 zero inject");
            if (vector == '0) seen_zero++;
            if (period == 0 && vector == SEED) period = i + 1;
        end
        check(seen_zero == 0, "R3 zero state", seen_zero, 0);
        check(period == 255, "R3 period", period, 255);

        // Restart, record vectors, then a combinational-only fault on node 6.
        cyc('0, 1'b1, 1'b0, "R1 restart clears");
        for (int i = 0; i < 16; i++) begin
            rec[i] = vector;
            cyc('0, 1'b0, 1'b0, "R4 zero inject");
        end
        cyc(F'(1) << 6, 1'b0, 1'b1, "R5 node6 pulse");
        cyc('0, 1'b0, 1'b0, "R6 node6 one cycle");
        cyc('0, 1'b0, 1'b0, "R5 node6 released");
        cyc('0, 1'b0, 1'b0, "R5 node6 released");

        // Restart replays the sequence; then a persistent parity fault on node 5.
        cyc('0, 1'b1, 1'b0, "R8 restart");
        for (int i = 0; i < 16; i++) begin
            check(vector == rec[i], "R8 replay", int'(vector), int'(rec[i]));
            cyc('0, 1'b0, 1'b0, "R4 zero inject");
        end
        cyc(F'(1) << 5, 1'b0, 1'b0, "R7 inject cycle quiet");
        for (int i = 0; i < 10; i++) cyc('0, 1'b0, 1'b1, "R7 persists");
        cyc('0, 1'b1, 1'b0, "R8 restart clears fault");
        for (int i = 0; i < 6; i++) cyc('0, 1'b0, 1'b0, "R8 clean after restart");

        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule